// File: doc/BRIEF.md
# Battery-Backup Rail Select and Chip-Enable Gate

This block is the digital side of a backup-power supervisor. Analog comparators supply two flags. One says the main supply is above the reset threshold. The other says the main supply is above the battery voltage. From these flags the block decides which rail feeds the protected memory, and it reports when that rail is the battery. If neither selection condition holds, the choice stays where it is, so the rail does not chatter near the crossover.

The block also gates a memory chip-enable. The gated enable passes the request only while the supply is good and the supervisor reset is released. While either condition fails, the gated enable is forced inactive, which protects the memory from writes. If an access is under way at the moment blocking starts, the gated enable stays active for a bounded window. The window is a fixed number of clock cycles worked out from the clock frequency and a hold time, 15 µs by default. The window ends early if the request is withdrawn. A new request made while blocking continues does not open a second window.

Top module: `bkup_ce_gate`

## Requirements
- R1: While `rst_n` is low, and after the first clock edge that samples it low, `batt_on` is 1, `rail_main` is 0 and `ce_gated_n` is 1.
- R2: At a clock edge that samples `supply_ok`=1 and `supply_gt_batt`=1, the rail moves to the main supply: afterwards `rail_main`=1 and `batt_on`=0.
- R3: At a clock edge that samples `supply_ok`=0 and `supply_gt_batt`=0, the rail moves to the battery: afterwards `rail_main`=0 and `batt_on`=1.
- R4: At a clock edge where exactly one of `supply_ok` and `supply_gt_batt` is 1, `rail_main` and `batt_on` keep their values.
- R5: At a clock edge that samples `supply_ok`=1 and `sup_reset`=0, `ce_gated_n` takes the sampled value of `ce_req_n`, with one cycle of latency.
- R6: Blocking means `sup_reset`=1 or `supply_ok`=0. If `ce_gated_n` is 1 or `ce_req_n` is 1 at the first edge that samples blocking, `ce_gated_n` is 1 after that edge.
- R7: If `ce_gated_n` is 0 and `ce_req_n` is 0 at the first edge that samples blocking, and the request stays low, `ce_gated_n` stays 0 through that edge and the next HOLD_CYC-1 edges. It rises at the HOLD_CYC-th edge after the first one. HOLD_CYC is ceil(CLK_HZ × HOLD_NS / 1e9), which is 750 at the defaults.
- R8: During a hold window, an edge that samples `ce_req_n`=1 ends the window, and `ce_gated_n` is 1 after that edge.
- R9: Once `ce_gated_n` is 1 during continuous blocking, it stays 1 until blocking ends, whatever `ce_req_n` does, including a new falling edge of the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, CLK_HZ |
| rst_n | input | 1 | Active-low synchronous block reset |
| supply_ok | input | 1 | Main supply above the reset threshold |
| supply_gt_batt | input | 1 | Main supply above the battery voltage |
| sup_reset | input | 1 | Supervisor reset asserted (active high) |
| ce_req_n | input | 1 | Chip-enable request, active low |
| rail_main | output | 1 | 1 = output rail on main supply, 0 = on battery |
| batt_on | output | 1 | 1 while the rail is on the battery |
| ce_gated_n | output | 1 | Gated chip-enable to the memory, active low |

## Verification
The properties assume that the comparator flags and the request are synchronous to `clk` and hold steady between edges. The bench meets this by changing every input on the falling clock edge. The hold-window property assumes that the request stays low throughout a window it has not ended. The stimulus keeps the request low across the full 750-cycle window, and it withdraws the request only in the cases that deliberately cut the window short. The rail properties assume no particular order of flag changes, so the stimulus walks through all four flag combinations, starting from both rail states.

// File: rtl/bkgate_pkg.sv
package bkgate_pkg;

    // Gate operating mode
    typedef enum logic [1:0] {
        GM_PASS  = 2'd0,   // request passed through
        GM_HOLD  = 2'd1,   // bounded hold of an in-flight access
        GM_BLOCK = 2'd2    // forced inactive
    } gate_mode_e;

    // Rail selection state
    typedef struct packed {
        logic on_batt;
    } rail_state_t;

    // Compute hold length in clock cycles, rounding up
    function automatic longint hold_cycles(input longint clk_hz, input longint hold_ns);
        longint prod;
        prod = clk_hz * hold_ns;
        return (prod + 64'd999_999_999) / 64'd1_000_000_000;
    endfunction

endpackage

// File: rtl/bkgate_rail.sv
module bkgate_rail
    import bkgate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic supply_gt_batt,
    output logic on_batt
);

    rail_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (supply_ok && supply_gt_batt) begin
            state_d.on_batt = 1'b0;
        end else if (!supply_ok && !supply_gt_batt) begin
            state_d.on_batt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{on_batt: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    assign on_batt = state_q.on_batt;

endmodule

// File: rtl/bkgate_hold.sv
module bkgate_hold
    import bkgate_pkg::*;
#(
    parameter int HOLD_CYC = 750,
    localparam int CNT_W   = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blocked,
    input  logic ce_req_n,
    output logic ce_out_n
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        gate_mode_e        mode;
        logic [CNT_W-1:0]  cnt;
        logic              ce_n;
    } gate_state_t;

    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!blocked) begin
            st_d.mode = GM_PASS;
            st_d.cnt  = '0;
            st_d.ce_n = ce_req_n;
        end else begin
            unique case (st_q.mode)
                GM_PASS: begin
                    if (!ce_req_n && !st_q.ce_n) begin
                        st_d.mode = GM_HOLD;
                        st_d.cnt  = CNT_LOAD;
                        st_d.ce_n = 1'b0;
                    end else begin
                        st_d.mode = GM_BLOCK;
                        st_d.ce_n = 1'b1;
                    end
                end
                GM_HOLD: begin
                    if (ce_req_n || (st_q.cnt == '0)) begin
                        st_d.mode = GM_BLOCK;
                        st_d.cnt  = '0;
                        st_d.ce_n = 1'b1;
                    end else begin
                        st_d.cnt  = st_q.cnt - 1'b1;
                        st_d.ce_n = 1'b0;
                    end
                end
                default: begin
                    st_d.mode = GM_BLOCK;
                    st_d.cnt  = '0;
                    st_d.ce_n = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= GM_BLOCK;
            st_q.cnt  <= '0;
            st_q.ce_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ce_out_n = st_q.ce_n;

endmodule

// File: rtl/bkup_ce_gate.sv
module bkup_ce_gate
    import bkgate_pkg::*;
#(
    parameter longint CLK_HZ  = 50_000_000,
    parameter longint HOLD_NS = 15_000,
    localparam int    HOLD_CYC = int'(hold_cycles(CLK_HZ, HOLD_NS))
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic supply_gt_batt,
    input  logic sup_reset,
    input  logic ce_req_n,
    output logic rail_main,
    output logic batt_on,
    output logic ce_gated_n
);

    logic on_batt;
    logic blocked;

    assign blocked = sup_reset || !supply_ok;

    bkgate_rail u_rail (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok      (supply_ok),
        .supply_gt_batt (supply_gt_batt),
        .on_batt        (on_batt)
    );

    bkgate_hold #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .blocked  (blocked),
        .ce_req_n (ce_req_n),
        .ce_out_n (ce_gated_n)
    );

    assign batt_on   = on_batt;
    assign rail_main = !on_batt;

endmodule

// File: rtl/bkup_ce_gate_chk.sv
module bkup_ce_gate_chk #(
    parameter int HOLD_CYC = 750
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic supply_gt_batt,
    input logic sup_reset,
    input logic ce_req_n,
    input logic batt_on,
    input logic ce_gated_n
);

    logic blk;
    int   low_run;

    assign blk = sup_reset || !supply_ok;

    // Count consecutive edges that sample blocking with the gate still active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= 0;
        end else if (blk && !ce_gated_n) begin
            if (low_run <= HOLD_CYC + 1) low_run <= low_run + 1;
        end else begin
            low_run <= 0;
        end
    end

    assert_rail_main_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && supply_gt_batt) |=> !batt_on);

    assert_rail_batt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok && !supply_gt_batt) |=> batt_on);

    assert_rail_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok != supply_gt_batt) |=> $stable(batt_on));

    assert_ce_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !sup_reset) |=> (ce_gated_n == $past(ce_req_n)));

    assert_ce_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && ce_req_n) |=> ce_gated_n);

    assert_hold_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= HOLD_CYC + 1);

    assert_no_rehold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && ce_gated_n) |=> (!(sup_reset || !supply_ok) || ce_gated_n));

endmodule

bind bkup_ce_gate bkup_ce_gate_chk #(
    .HOLD_CYC (HOLD_CYC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok      (supply_ok),
    .supply_gt_batt (supply_gt_batt),
    .sup_reset      (sup_reset),
    .ce_req_n       (ce_req_n),
    .batt_on        (batt_on),
    .ce_gated_n     (ce_gated_n)
);

// File: tb/test_bkup_ce_gate.sv
module test_bkup_ce_gate;

    localparam int HOLD = 750;  // 50 MHz x 15 us

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic supply_gt_batt = 1'b1;
    logic sup_reset = 1'b0;
    logic ce_req_n = 1'b1;
    logic rail_main, batt_on, ce_gated_n;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        bit    chk_rail;
        logic  exp_batt;
        bit    chk_ce;
        logic  exp_ce;
        string tag;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    bkup_ce_gate i_bkup_ce_gate (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok      (supply_ok),
        .supply_gt_batt (supply_gt_batt),
        .sup_reset      (sup_reset),
        .ce_req_n       (ce_req_n),
        .rail_main      (rail_main),
        .batt_on        (batt_on),
        .ce_gated_n     (ce_gated_n)
    );

    // Driver: set inputs on the falling edge, queue what the next rising edge must produce
    task automatic step(input logic r, input logic ok, input logic gt, input logic sr,
                        input logic rq, input bit cr, input logic eb,
                        input bit cc, input logic ec, input string tag);
        @(negedge clk);
        rst_n = r; supply_ok = ok; supply_gt_batt = gt; sup_reset = sr; ce_req_n = rq;
        sb.push_back('{cr, eb, cc, ec, tag});
    endtask

    // Monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                if (it.chk_rail) begin
                    tests++;
                    if (batt_on !== it.exp_batt || rail_main !== !it.exp_batt) begin
                        fails++;
                        $display("FAIL %s rail: batt_on=%b rail_main=%b expected batt_on=%b rail_main=%b",
                                 it.tag, batt_on, rail_main, it.exp_batt, !it.exp_batt);
                    end
                end
                if (it.chk_ce) begin
                    tests++;
                    if (ce_gated_n !== it.exp_ce) begin
                        fails++;
                        $display("FAIL %s ce: ce_gated_n=%b expected %b", it.tag, ce_gated_n, it.exp_ce);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(0, 1, 1, 0, 1, 1, 1, 1, 1, "R1");
        step(0, 1, 1, 0, 0, 1, 1, 1, 1, "R1");
        // R2: leave reset with supply good and above battery
        step(1, 1, 1, 0, 1, 1, 0, 1, 1, "R2");
        // R5: pass-through of the request
        step(1, 1, 1, 0, 0, 1, 0, 1, 0, "R5");
        step(1, 1, 1, 0, 1, 0, 0, 1, 1, "R5");
        step(1, 1, 1, 0, 0, 0, 0, 1, 0, "R5");
        step(1, 1, 1, 0, 1, 0, 0, 1, 1, "R5");
        // R4: mixed flags keep main
        step(1, 1, 0, 0, 1, 1, 0, 1, 1, "R4");
        step(1, 0, 1, 0, 1, 1, 0, 1, 1, "R4");
        // R3: both low selects battery
        step(1, 0, 0, 0, 1, 1, 1, 1, 1, "R3");
        // R4: mixed flags keep battery
        step(1, 1, 0, 0, 1, 1, 1, 1, 1, "R4");
        step(1, 0, 1, 0, 1, 1, 1, 1, 1, "R4");
        // R2: back to main
        step(1, 1, 1, 0, 1, 1, 0, 1, 1, "R2");
        // R6: blocking with no access in progress
        step(1, 1, 1, 1, 1, 0, 0, 1, 1, "R6");
        // R9: new request during blocking gets no window
        step(1, 1, 1, 1, 0, 0, 0, 1, 1, "R9");
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 0, 0, 0, 1, 1, "R9");
        // R5: release reset, request passes
        step(1, 1, 1, 0, 0, 0, 0, 1, 0, "R5");
        // R7: full hold window
        step(1, 1, 1, 1, 0, 0, 0, 1, 0, "R7");
        for (int i = 1; i < HOLD; i++) step(1, 1, 1, 1, 0, 0, 0, 1, 0, "R7");
        step(1, 1, 1, 1, 0, 0, 0, 1, 1, "R7");
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, 0, 0, 1, 1, "R9");
        // re-arm
        step(1, 1, 1, 0, 1, 0, 0, 1, 1, "R5");
        step(1, 1, 1, 0, 0, 0, 0, 1, 0, "R5");
        // R8: request released inside window
        step(1, 1, 1, 1, 0, 0, 0, 1, 0, "R7");
        for (int i = 0; i < 9; i++) step(1, 1, 1, 1, 0, 0, 0, 1, 0, "R7");
        step(1, 1, 1, 1, 1, 0, 0, 1, 1, "R8");
        step(1, 1, 1, 1, 0, 0, 0, 1, 1, "R9");
        step(1, 1, 1, 1, 0, 0, 0, 1, 1, "R9");
        // re-arm
        step(1, 1, 1, 0, 0, 0, 0, 1, 0, "R5");
        // R7/R8: low supply alone also opens a window; rail stays main (R4)
        step(1, 0, 1, 0, 0, 1, 0, 1, 0, "R7");
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0, 1, 0, 1, 0, "R7");
        step(1, 0, 1, 0, 1, 1, 0, 1, 1, "R8");
        // R6: request falls on the same edge blocking starts
        step(1, 1, 1, 0, 1, 0, 0, 1, 1, "R5");
        step(1, 1, 1, 1, 0, 0, 0, 1, 1, "R6");
        step(1, 1, 1, 1, 0, 0, 0, 1, 1, "R9");
        // R1: reset again from the main rail
        step(0, 1, 1, 0, 0, 1, 1, 1, 1, "R1");
        step(1, 1, 1, 0, 1, 0, 0, 0, 0, "none");
        @(posedge clk);
        #8;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule